// File: doc/BRIEF.md
# Serial Control Port Target with Data-Pending Interrupt

This block is the device side of a four-wire serial control port. It lets an external host controller write bytes into the chip and read bytes out of it. Internally it pushes received bytes to an inbound byte queue and pops transmitted bytes from an outbound byte queue. Both queues sit outside the block. Serial clock, select and data lines are brought into the system clock domain through synchronizers, and all framing runs on the system clock. The serial clock must therefore be several times slower than the system clock.

A transaction opens when the active-low select goes low. The first byte holds the target's 7-bit address in its upper seven bits and a direction flag in its lowest bit. Every byte travels most significant bit first. The host samples on the rising serial clock edge, and the block changes its output only after a falling edge. An active-low interrupt line tells the host that outbound bytes are waiting. During a read, the block releases that line only at one bit position of a byte, so the host knows the current byte is the last one worth reading.

Top module: `spi_ctl_slave`

## Requirements
- R1: A transaction starts when spi_cs_n falls. The first byte carries the address in bits 7..1 and a direction flag in bit 0 (1 = read, 0 = write). A read pushes nothing inbound, and a write pops nothing outbound.
- R2: If the received address differs from dev_addr, the rest of the transaction is ignored: no push, no pop, and spi_miso_oe stays low.
- R3: In a matched write, every complete 8-bit byte shifted in MSB first is pushed once to the inbound queue (ib_push pulse with ib_data).
- R4: Bits of an incomplete byte that remain when spi_cs_n rises are dropped without a push.
- R5: In a matched read, one byte is popped from the outbound queue as each byte's shift begins. Its bits appear MSB first on spi_miso, change after falling serial clock edges, and are stable at the rising edge.
- R6: A read byte whose shift begins with the outbound queue empty is sent as 0x00, and no pop is issued.
- R7: spi_miso_oe is high only during the data phase of a matched read. It is low while spi_cs_n is high, and spi_miso is 0 whenever spi_miso_oe is low.
- R8: Outside a read data phase, irq_n is low exactly when the outbound queue is non-empty. After reset with an empty queue it is high.
- R9: During a read data phase, irq_n can rise only at the rising serial clock edge of the 7th bit of a byte (the second-to-last bit), and only if the outbound queue is empty at that point.
- R10: After irq_n rises in a read data phase, it stays high until at least the next rising serial clock edge. At that edge it falls again if data has become pending.
- R11: ob_pop and ib_push are single-cycle pulses, and ob_pop never occurs while ob_empty is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Address this target answers to |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host (idles low) |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the spi_miso pad; the pad floats when low |
| irq_n | output | 1 | Active-low data-pending request |
| ob_empty | input | 1 | Outbound queue is empty |
| ob_data | input | 8 | Head byte of the outbound queue |
| ob_pop | output | 1 | Remove the head byte of the outbound queue |
| ib_push | output | 1 | Inbound byte valid |
| ib_data | output | 8 | Inbound byte |

## Verification
Writes send every byte value from 0x00 to 0xFF in one long transaction, which shows any stuck or swapped bit in the receive path. A sweep over all 128 addresses shows that exactly one address is accepted. A read attempt at each single-bit neighbour of the device address shows that every address bit takes part in the compare. Reads drain 256 queued values in blocks of sixteen; the irq_n value recorded after every rising edge shows that the release happens only on the second-to-last bit of the final byte, and separately that an empty queue yields 0x00 without a pop. A byte queued just after the release shows that irq_n holds high up to the next rising edge and then falls. Truncated writes show that a partial byte is dropped.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_SKIP  = 3'd4
  } xfer_state_t;

endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_n_o,
  output logic mosi_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b100;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_prev_q;

  assign raw = {cs_n_i, sclk_i, mosi_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    assign pipe_d = {pipe_q[STAGES-2:0], raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {STAGES{RST_VAL[g]}};
      end else begin
        pipe_q <= pipe_d;
      end
    end

    assign synced[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= synced[1];
    end
  end

  assign cs_n_o      = synced[2];
  assign mosi_o      = synced[0];
  assign sclk_rise_o = synced[1] & ~sclk_prev_q;
  assign sclk_fall_o = ~synced[1] & sclk_prev_q;

endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk_rise,
  input  logic              mosi,
  input  logic [DATA_W-2:0] dev_addr,
  output xfer_state_t       state,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] rx_word,
  output logic              byte_end,
  output logic              enter_read
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  xfer_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q;
  logic              sr_en;
  logic              active;

  assign active  = !cs_n && (state_q != ST_IDLE);
  assign rx_word = {sr_q[DATA_W-2:0], mosi};
  assign sr_en   = active && sclk_rise;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    enter_read = 1'b0;
    byte_end   = sr_en && (cnt_q == LAST);
    if (cs_n) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (state_q == ST_IDLE) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (sclk_rise) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if ((state_q == ST_ADDR) && (cnt_q == LAST)) begin
        if (rx_word[DATA_W-1:1] == dev_addr) begin
          state_d    = rx_word[0] ? ST_READ : ST_WRITE;
          enter_read = rx_word[0];
        end else begin
          state_d = ST_SKIP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (sr_en) begin
        sr_q <= rx_word;
      end
    end
  end

  assign state   = state_q;
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/spi_ctl_txshift.sv
module spi_ctl_txshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active,
  input  logic              load,
  input  logic              sclk_fall,
  input  logic              ob_empty,
  input  logic [DATA_W-1:0] ob_data,
  output logic              ob_pop,
  output logic              miso,
  output logic              miso_oe
);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic              sr_en;
  logic              bit_q;

  assign ob_pop = load && !ob_empty;
  assign sr_en  = load || sclk_fall;

  always_comb begin
    if (load) begin
      sr_d = ob_empty ? '0 : ob_data;
    end else begin
      sr_d = {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      if (sr_en) begin
        sr_q <= sr_d;
      end
      if (sclk_fall) begin
        bit_q <= sr_q[DATA_W-1];
      end
    end
  end

  assign miso_oe = rd_active;
  assign miso    = rd_active & bit_q;

endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_active,
  input  logic             sclk_rise,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             ob_empty,
  output logic             irq_n
);

  localparam logic [CNT_W-1:0] RELEASE_BIT = CNT_W'(DATA_W - 2);

  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (!rd_active) begin
      irq_d = ob_empty;
    end else if (sclk_rise) begin
      if (bit_cnt == RELEASE_BIT) begin
        irq_d = ob_empty;
      end else if (!ob_empty) begin
        irq_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b1;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_n = irq_q;

endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave
  import spi_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] dev_addr,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              irq_n,
  input  logic              ob_empty,
  input  logic [DATA_W-1:0] ob_data,
  output logic              ob_pop,
  output logic              ib_push,
  output logic [DATA_W-1:0] ib_data
);

  localparam int CNT_W = $clog2(DATA_W);

  logic              cs_n_s, mosi_s, sclk_rise, sclk_fall;
  xfer_state_t       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_word;
  logic              byte_end, enter_read;
  logic              rd_active, load, push_d;
  logic              push_q;
  logic [DATA_W-1:0] data_q;

  spi_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (spi_cs_n),
    .sclk_i     (spi_sclk),
    .mosi_i     (spi_mosi),
    .cs_n_o     (cs_n_s),
    .mosi_o     (mosi_s),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall)
  );

  spi_ctl_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n_s),
    .sclk_rise (sclk_rise),
    .mosi      (mosi_s),
    .dev_addr  (dev_addr),
    .state     (state),
    .bit_cnt   (bit_cnt),
    .rx_word   (rx_word),
    .byte_end  (byte_end),
    .enter_read(enter_read)
  );

  assign rd_active = (state == ST_READ);
  assign load      = enter_read || (byte_end && rd_active);
  assign push_d    = byte_end && (state == ST_WRITE);

  spi_ctl_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_active(rd_active),
    .load     (load),
    .sclk_fall(sclk_fall),
    .ob_empty (ob_empty),
    .ob_data  (ob_data),
    .ob_pop   (ob_pop),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  spi_ctl_irq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_active(rd_active),
    .sclk_rise(sclk_rise),
    .bit_cnt  (bit_cnt),
    .ob_empty (ob_empty),
    .irq_n    (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q <= 1'b0;
      data_q <= '0;
    end else begin
      push_q <= push_d;
      if (push_d) begin
        data_q <= rx_word;
      end
    end
  end

  assign ib_push = push_q;
  assign ib_data = data_q;

endmodule

// File: rtl/spi_ctl_slave_chk.sv
module spi_ctl_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic spi_miso_oe,
  input logic irq_n,
  input logic ob_empty,
  input logic ob_pop,
  input logic ib_push
);

  // R7: a select held high for several cycles leaves the pad undriven
  p_float_when_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
     && $past(spi_cs_n, 4)) |-> !spi_miso_oe);

  // R7: output data is parked at 0 when not driven
  p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);

  // R11: no pop from an empty outbound queue
  p_no_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ob_pop |-> !ob_empty);

  // R11: pops are single-cycle pulses
  p_pop_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ob_pop |=> !ob_pop);

  // R11: pushes are single-cycle pulses
  p_push_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ib_push |=> !ib_push);

  // R3: inbound bytes never appear while a read is driving the pad
  p_push_not_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ib_push |-> !spi_miso_oe);

  // R9: the request is released only when the queue was empty
  p_release_needs_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(ob_empty));

  // R8: the request is raised only when data was pending
  p_raise_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> !$past(ob_empty));

endmodule

bind spi_ctl_slave spi_ctl_slave_chk u_chk (.*);

// File: tb/spi_ctl_slave_tb.sv
module spi_ctl_slave_tb;

  localparam logic [6:0] DEV = 7'h2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, irq_n;
  logic ob_empty, ob_pop, ib_push;
  logic [7:0] ob_data, ib_data;

  always #10 clk = ~clk;

  spi_ctl_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_addr   (DEV),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .irq_n      (irq_n),
    .ob_empty   (ob_empty),
    .ob_data    (ob_data),
    .ob_pop     (ob_pop),
    .ib_push    (ib_push),
    .ib_data    (ib_data)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // outbound queue model
  logic [7:0] ob_mem [16];
  int ob_wr = 0;
  int ob_rd = 0;
  int pop_cnt = 0;
  int pop_err = 0;
  assign ob_empty = (ob_wr == ob_rd);
  assign ob_data  = ob_mem[ob_rd % 16];

  always @(posedge clk) begin
    if (ob_pop) begin
      pop_cnt <= pop_cnt + 1;
      if (ob_wr == ob_rd) pop_err <= pop_err + 1;
      else ob_rd <= ob_rd + 1;
    end
  end

  // inbound capture
  logic [7:0] ib_log [1024];
  int ib_cnt = 0;
  int oe_cnt = 0;
  always @(posedge clk) begin
    if (ib_push) begin
      ib_log[ib_cnt % 1024] <= ib_data;
      ib_cnt <= ib_cnt + 1;
    end
    if (spi_miso_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic lo_phase(input logic b, output logic m);
    spi_mosi = b;
    half();
    m = spi_miso;
    spi_sclk = 1'b1;
  endtask

  task automatic hi_phase(output logic q);
    half();
    q = irq_n;
    spi_sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] v, output logic [7:0] r, output logic [7:0] iq);
    for (int i = 7; i >= 0; i--) begin
      logic m, q;
      lo_phase(v[i], m);
      r[i] = m;
      hi_phase(q);
      iq[i] = q;
    end
  endtask

  task automatic open_xfer(input logic [6:0] a, input logic rw);
    logic [7:0] r, iq;
    spi_cs_n = 1'b0;
    half();
    xbyte({a, rw}, r, iq);
  endtask

  task automatic close_xfer();
    half();
    spi_cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic ob_put(input logic [7:0] v);
    ob_mem[ob_wr % 16] = v;
    ob_wr++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] r, iq;
    int base, pbase, obase;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R8 irq_n after reset", irq_n, 1);
    chk("R7 oe after reset", spi_miso_oe, 0);
    chk("R11 no pop after reset", pop_cnt, 0);
    chk("R11 no push after reset", ib_cnt, 0);

    // R3: every byte value in one write
    base = ib_cnt; pbase = pop_cnt; obase = oe_cnt;
    open_xfer(DEV, 1'b0);
    for (int v = 0; v < 256; v++) xbyte(v[7:0], r, iq);
    close_xfer();
    chk("R3 push count", ib_cnt - base, 256);
    for (int v = 0; v < 256; v++) chk("R3 pushed byte", ib_log[(base + v) % 1024], v);
    chk("R1 write pops nothing", pop_cnt - pbase, 0);
    chk("R7 write never drives", oe_cnt - obase, 0);

    // R4: trailing partial byte dropped
    base = ib_cnt;
    open_xfer(DEV, 1'b0);
    xbyte(8'h11, r, iq);
    xbyte(8'h22, r, iq);
    for (int i = 0; i < 5; i++) begin
      logic m, q;
      lo_phase(1'b1, m);
      hi_phase(q);
    end
    close_xfer();
    chk("R4 partial push count", ib_cnt - base, 2);
    chk("R4 first byte", ib_log[base % 1024], 8'h11);
    chk("R4 second byte", ib_log[(base + 1) % 1024], 8'h22);

    // R2: address sweep on writes
    for (int a = 0; a < 128; a++) begin
      base = ib_cnt;
      open_xfer(a[6:0], 1'b0);
      xbyte(a[7:0] ^ 8'h5A, r, iq);
      close_xfer();
      chk("R2 address filter pushes", ib_cnt - base, (a == DEV) ? 1 : 0);
      if (a == DEV) chk("R2 accepted byte", ib_log[base % 1024], a ^ 8'h5A);
    end

    // R2: reads to single-bit neighbours are ignored
    ob_put(8'hE7);
    repeat (6) @(negedge clk);
    chk("R8 irq_n low when pending", irq_n, 0);
    for (int k = 0; k < 7; k++) begin
      logic [6:0] na;
      na = DEV ^ (7'd1 << k);
      pbase = pop_cnt; obase = oe_cnt;
      open_xfer(na, 1'b1);
      xbyte(8'h00, r, iq);
      close_xfer();
      chk("R2 mismatch no pop", pop_cnt - pbase, 0);
      chk("R2 mismatch no drive", oe_cnt - obase, 0);
      chk("R2 mismatch irq stays low", iq, 8'h00);
    end

    // R5/R9: drain 256 values in blocks of 16
    base = ib_cnt;
    pbase = pop_cnt;
    r = 8'h00;
    for (int v = 0; v < 1; v++) begin
      // first consume the pending E7
      open_xfer(DEV, 1'b1);
      xbyte(8'h00, r, iq);
      close_xfer();
      chk("R5 pending byte read", r, 8'hE7);
      chk("R9 single byte release at 7th bit", iq, 8'h03);
    end
    for (int blk = 0; blk < 16; blk++) begin
      for (int j = 0; j < 16; j++) ob_put(8'((blk * 16 + j) ^ 8'hA5));
      open_xfer(DEV, 1'b1);
      half();
      chk("R7 read drives pad", spi_miso_oe, 1);
      for (int j = 0; j < 16; j++) begin
        xbyte(8'h00, r, iq);
        chk("R5 read byte", r, (blk * 16 + j) ^ 8'hA5);
        chk("R9 irq pattern", iq, (j == 15) ? 8'h03 : 8'h00);
      end
      close_xfer();
      chk("R7 pad released after select", spi_miso_oe, 0);
    end
    chk("R5 pop count", pop_cnt - pbase, 257);
    chk("R1 read pushes nothing", ib_cnt - base, 0);

    // R6: empty queue gives zero, no pop
    pbase = pop_cnt;
    chk("R8 irq_n high when empty", irq_n, 1);
    open_xfer(DEV, 1'b1);
    xbyte(8'hFF, r, iq);
    chk("R6 empty byte 1", r, 8'h00);
    chk("R9 stays high when empty", iq, 8'hFF);
    xbyte(8'hFF, r, iq);
    chk("R6 empty byte 2", r, 8'h00);
    close_xfer();
    chk("R6 no pop on empty", pop_cnt - pbase, 0);

    // R10: data arriving after release
    ob_put(8'hC3);
    repeat (6) @(negedge clk);
    open_xfer(DEV, 1'b1);
    for (int i = 7; i >= 1; i--) begin
      logic m, q;
      lo_phase(1'b0, m);
      r[i] = m;
      hi_phase(q);
      if (i == 1) chk("R9 release at 7th bit", q, 1);
    end
    begin
      logic m, q;
      ob_put(8'h96);
      lo_phase(1'b0, m);
      r[0] = m;
      chk("R10 holds high before next rise", irq_n, 1);
      hi_phase(q);
      chk("R10 falls at next rise", q, 0);
    end
    chk("R5 byte before release", r, 8'hC3);
    xbyte(8'h00, r, iq);
    chk("R5 late byte", r, 8'h96);
    chk("R9 late byte release", iq, 8'h03);
    close_xfer();
    chk("R11 no underflow", pop_err, 0);

    summary();
  end

endmodule